// File: doc/BRIEF.md
# Barrier-Aware Warp Coalescer

This block keeps a one-bit barrier flag for every work item resident on a multiprocessor (1024 by default) and turns the items that are free to run into 32-wide issue groups. A flag of 1 marks an item that is waiting at a barrier, and a flag of 0 marks an item that may run. The rest of the core raises a per-item set strobe when an item arrives at a barrier and a per-item clear strobe when its barrier resolves.

Scanning takes place only while at least one flag is raised. In each idle cycle the scan looks at the whole table. If some aligned group of 32 items is entirely runnable, that group leaves unchanged as an ordinary warp. If no such group exists, the lowest-indexed runnable items are packed into a temporary warp. A warp is held in a register and presented eight lanes at a time over four phases. The consumer steps through the phases with an accept strobe. Every item placed in a warp is reserved until its flag is raised again, so no item can be issued twice between two of its barriers.

Top module: `bsc_warp_coalescer`

## Requirements
- R1: During and after reset, every flag is 0, no item is reserved, `warp_valid_o` is low, `phase_o` is 0 and `coalesced_o` is 0.
- R2: A set strobe for an item raises its flag and drops its reservation. A clear strobe lowers its flag. When both strobes hit the same item in one cycle, the set wins.
- R3: While no flag is raised anywhere in the table, no warp is formed.
- R4: If any aligned group (items g*WARP to g*WARP+WARP-1) has every item clear and unreserved, the lowest such group is issued with `coalesced_o` low, and slot s carries item g*WARP+s.
- R5: If no such group exists and at least WARP items are clear and unreserved, the WARP lowest-indexed of them are issued in ascending order over slots 0 to WARP-1, with `coalesced_o` high.
- R6: If neither condition holds, nothing is issued until the strobes change the table.
- R7: Every item issued in a warp of either kind stays reserved, and cannot be issued again, until its flag is set again.
- R8: A warp is shown as WARP/LANES phases. During phase p, lane l of `lane_ids_o` (bits l*ID_W upward) carries slot p*LANES+l. The phase starts at 0 and advances only on a cycle with `accept_i` high. While `accept_i` is low the outputs hold. `warp_valid_o` drops after the last phase is accepted.
- R9: After a warp is committed, `warp_valid_o` rises on the next clock edge. At least one idle cycle separates two warps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | N_ITEMS | Per-item strobe: item reached a barrier |
| clr_i | input | N_ITEMS | Per-item strobe: item's barrier resolved |
| accept_i | input | 1 | Consumer takes the current phase |
| warp_valid_o | output | 1 | A warp phase is being presented |
| coalesced_o | output | 1 | 1 for a gathered temporary warp, 0 for an aligned default warp |
| phase_o | output | clog2(WARP/LANES) | Index of the current phase |
| lane_ids_o | output | LANES*clog2(N_ITEMS) | Work-item identifiers for the lanes of this phase |

## Verification
The bench builds the block with 64 items, warps of 8 and 4 lanes, which gives 8 aligned groups and 2 phases. At that size a short script of strobe patterns can fill and drain the table by hand. It covers a default group blocked by one reserved member, a set and a clear on the same item, a fully cleared table with no warp formed, and a run of four back-to-back gathered warps that drains the scattered survivors in ascending order. A reference model inside the bench predicts every warp from the requirements.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } bsc_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/bsc_flag_table.sv
module bsc_flag_table #(
  parameter int unsigned N_ITEMS = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ITEMS-1:0] set_i,
  input  logic [N_ITEMS-1:0] clr_i,
  input  logic [N_ITEMS-1:0] claim_i,
  output logic [N_ITEMS-1:0] elig_o,
  output logic               pend_any_o
);

  logic [N_ITEMS-1:0] pend_q;
  logic [N_ITEMS-1:0] rsv_q;
  logic               armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      rsv_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      // set dominates clear
      pend_q  <= set_i | (pend_q & ~clr_i);
      // a fresh barrier releases the reservation
      rsv_q   <= ~set_i & (rsv_q | claim_i);
      armed_q <= 1'b1;
    end
  end

  assign elig_o     = ~pend_q & ~rsv_q;
  assign pend_any_o = |pend_q;

  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((pend_q & $past(set_i)) == $past(set_i)));

  // R2
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0));

  // R7
  rsv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsv_q & pend_q) == '0);

endmodule

// File: rtl/bsc_group_scan.sv
module bsc_group_scan
  import bsc_pkg::*;
#(
  parameter int unsigned N_ITEMS = 1024,
  parameter int unsigned WARP    = 32,
  localparam int unsigned N_GRP  = N_ITEMS / WARP,
  localparam int unsigned GRP_W  = clog2_min1(N_GRP)
) (
  input  logic [N_ITEMS-1:0] elig_i,
  output logic               hit_o,
  output logic [GRP_W-1:0]   grp_o
);

  logic [N_GRP-1:0] full;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign full[g] = &elig_i[g*WARP +: WARP];
  end

  // lowest fully ready group wins
  always_comb begin
    hit_o = 1'b0;
    grp_o = '0;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (full[g]) begin
        hit_o = 1'b1;
        grp_o = GRP_W'(g);
      end
    end
  end

endmodule

// File: rtl/bsc_compactor.sv
module bsc_compactor
  import bsc_pkg::*;
#(
  parameter int unsigned N_ITEMS = 1024,
  parameter int unsigned WARP    = 32,
  localparam int unsigned ID_W   = clog2_min1(N_ITEMS)
) (
  input  logic [N_ITEMS-1:0]   elig_i,
  output logic                 enough_o,
  output logic [N_ITEMS-1:0]   sel_o,
  output logic [WARP*ID_W-1:0] ids_o
);

  int unsigned cnt;

  // rank-ordered gather of the lowest WARP ready items
  always_comb begin
    cnt   = 0;
    sel_o = '0;
    ids_o = '0;
    for (int i = 0; i < N_ITEMS; i++) begin
      if (elig_i[i] && cnt < WARP) begin
        sel_o[i]                  = 1'b1;
        ids_o[cnt*ID_W +: ID_W]   = ID_W'(i);
        cnt                       = cnt + 1;
      end
    end
    enough_o = (cnt == WARP);
  end

endmodule

// File: rtl/bsc_warp_coalescer.sv
module bsc_warp_coalescer
  import bsc_pkg::*;
#(
  parameter int unsigned N_ITEMS  = 1024,
  parameter int unsigned WARP     = 32,
  parameter int unsigned LANES    = 8,
  localparam int unsigned PHASES  = WARP / LANES,
  localparam int unsigned ID_W    = clog2_min1(N_ITEMS),
  localparam int unsigned PH_W    = clog2_min1(PHASES),
  localparam int unsigned GRP_W   = clog2_min1(N_ITEMS / WARP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_ITEMS-1:0]    set_i,
  input  logic [N_ITEMS-1:0]    clr_i,
  input  logic                  accept_i,
  output logic                  warp_valid_o,
  output logic                  coalesced_o,
  output logic [PH_W-1:0]       phase_o,
  output logic [LANES*ID_W-1:0] lane_ids_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [N_ITEMS-1:0]   elig;
  logic                 pend_any;
  logic                 grp_hit;
  logic [GRP_W-1:0]     grp;
  logic                 enough;
  logic [N_ITEMS-1:0]   gat_sel;
  logic [WARP*ID_W-1:0] gat_ids;
  logic [WARP*ID_W-1:0] def_ids;
  logic [N_ITEMS-1:0]   claim;
  logic                 commit;

  bsc_state_e           state_q;
  logic [PH_W-1:0]      phase_q;
  logic                 coal_q;
  logic [WARP*ID_W-1:0] ids_q;

  bsc_flag_table #(.N_ITEMS(N_ITEMS)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .claim_i    (claim),
    .elig_o     (elig),
    .pend_any_o (pend_any)
  );

  bsc_group_scan #(.N_ITEMS(N_ITEMS), .WARP(WARP)) u_scan (
    .elig_i (elig),
    .hit_o  (grp_hit),
    .grp_o  (grp)
  );

  bsc_compactor #(.N_ITEMS(N_ITEMS), .WARP(WARP)) u_gather (
    .elig_i   (elig),
    .enough_o (enough),
    .sel_o    (gat_sel),
    .ids_o    (gat_ids)
  );

  assign commit = (state_q == ST_IDLE) && pend_any && (grp_hit || enough);

  always_comb begin
    for (int s = 0; s < WARP; s++) begin
      def_ids[s*ID_W +: ID_W] = ID_W'(int'(grp) * WARP + s);
    end
  end

  always_comb begin
    for (int i = 0; i < N_ITEMS; i++) begin
      if (grp_hit) claim[i] = commit && ((i / WARP) == int'(grp));
      else         claim[i] = commit && gat_sel[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      coal_q  <= 1'b0;
      ids_q   <= '0;
    end else if (commit) begin
      state_q <= ST_ISSUE;
      phase_q <= '0;
      coal_q  <= !grp_hit;
      ids_q   <= grp_hit ? def_ids : gat_ids;
    end else if (state_q == ST_ISSUE && accept_i) begin
      if (phase_q == LAST_PH) begin
        state_q <= ST_IDLE;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign warp_valid_o = (state_q == ST_ISSUE);
  assign coalesced_o  = coal_q;
  assign phase_o      = phase_q;
  assign lane_ids_o   = ids_q[int'(phase_q)*LANES*ID_W +: LANES*ID_W];

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warp_valid_o && !accept_i) |=>
      (warp_valid_o && $stable(phase_o) && $stable(lane_ids_o) && $stable(coalesced_o)));

  // R8
  last_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warp_valid_o && accept_i && phase_o == LAST_PH) |=> !warp_valid_o);

  // R8
  phase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warp_valid_o) |-> (phase_o == '0));

  // R3
  no_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warp_valid_o && !pend_any) |=> !warp_valid_o);

endmodule

// File: tb/sim_bsc_warp_coalescer.sv
module sim_bsc_warp_coalescer;

  localparam int N    = 64;
  localparam int W    = 8;
  localparam int L    = 4;
  localparam int PH   = W / L;
  localparam int IDW  = 6;
  localparam int NV   = 10;

  // {set mask, clear mask}
  localparam logic [127:0] VEC [NV] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {64'h0, 64'h0000_0000_00FF_0000},
    {64'h0, 64'h8004_0100_4000_2222},
    {64'h0, 64'h0000_0000_0000_007F},
    {64'h0, 64'h0000_00FF_0000_0080},
    {64'h0000_0000_0000_0022, 64'h0000_0000_0000_0002},
    {64'h0, 64'h0000_0000_0000_0020},
    {64'h0, 64'h0000_0000_0000_0402},
    {64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'h8000_0000_0000_0000, 64'h0}
  };
  localparam int NWARPS [NV] = '{0, 1, 1, 0, 1, 0, 0, 1, 0, 4};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  set_i = '0;
  logic [N-1:0]  clr_i = '0;
  logic          accept_i = 1'b0;
  logic          warp_valid_o;
  logic          coalesced_o;
  logic [0:0]    phase_o;
  logic [L*IDW-1:0] lane_ids_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_rsv  = '0;

  always #2.5 clk_i = ~clk_i;

  bsc_warp_coalescer #(.N_ITEMS(N), .WARP(W), .LANES(L)) u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_i),
    .clr_i        (clr_i),
    .accept_i     (accept_i),
    .warp_valid_o (warp_valid_o),
    .coalesced_o  (coalesced_o),
    .phase_o      (phase_o),
    .lane_ids_o   (lane_ids_o)
  );

  function automatic string tag_of(input int v);
    case (v)
      0, 3:    return "R6";
      1:       return "R4";
      2, 9:    return "R5";
      4:       return "R7";
      5, 6, 7: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model of the next committed warp
  task automatic predict(output bit has, output bit coal, output int ids [W]);
    logic [N-1:0] el;
    int cnt;
    has = 1'b0; coal = 1'b0;
    for (int s = 0; s < W; s++) ids[s] = 0;
    el = ~m_pend & ~m_rsv;
    if (m_pend == '0) return;
    for (int g = 0; g < N / W; g++) begin
      if (!has && &el[g*W +: W]) begin
        has = 1'b1;
        for (int s = 0; s < W; s++) begin
          ids[s] = g * W + s;
          m_rsv[g*W + s] = 1'b1;
        end
      end
    end
    if (has) return;
    cnt = 0;
    for (int i = 0; i < N; i++) if (el[i]) cnt++;
    if (cnt < W) return;
    has = 1'b1; coal = 1'b1; cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (el[i] && cnt < W) begin
        ids[cnt] = i;
        m_rsv[i] = 1'b1;
        cnt++;
      end
    end
  endtask

  initial begin
    bit has, coal;
    int ids [W];
    int nw, seen;
    logic [L*IDW-1:0] held;

    repeat (4) @(negedge clk_i);
    // R1
    chk(warp_valid_o == 1'b0, "R1", "valid in reset", int'(warp_valid_o), 0);
    chk(phase_o == 1'b0, "R1", "phase in reset", int'(phase_o), 0);
    chk(coalesced_o == 1'b0, "R1", "kind in reset", int'(coalesced_o), 0);
    rst_ni = 1'b1;
    seen = 0;
    repeat (4) begin
      @(negedge clk_i);
      if (warp_valid_o) seen++;
    end
    chk(seen == 0, "R1", "valid after reset", seen, 0);

    for (int v = 0; v < NV; v++) begin
      set_i = VEC[v][127:64];
      clr_i = VEC[v][63:0];
      @(negedge clk_i);
      set_i = '0;
      clr_i = '0;
      m_pend = VEC[v][127:64] | (m_pend & ~VEC[v][63:0]);
      m_rsv  = ~VEC[v][127:64] & m_rsv;
      nw = 0;
      forever begin
        predict(has, coal, ids);
        if (!has) begin
          seen = 0;
          repeat (4) begin
            @(negedge clk_i);
            if (warp_valid_o) seen++;
          end
          // R3 R6: nothing committable
          chk(seen == 0, tag_of(v), "unexpected warp", seen, 0);
          break;
        end
        seen = 0;
        for (int k = 0; k < 4; k++) begin
          if (!warp_valid_o) @(negedge clk_i);
        end
        // R9
        chk(warp_valid_o == 1'b1, "R9", "warp did not appear", int'(warp_valid_o), 1);
        if (!warp_valid_o) break;
        chk(coalesced_o == coal, tag_of(v), "kind", int'(coalesced_o), int'(coal));
        for (int p = 0; p < PH; p++) begin
          chk(int'(phase_o) == p, "R8", "phase", int'(phase_o), p);
          for (int l = 0; l < L; l++) begin
            chk(int'(lane_ids_o[l*IDW +: IDW]) == ids[p*L + l], tag_of(v),
                "lane id", int'(lane_ids_o[l*IDW +: IDW]), ids[p*L + l]);
          end
          if (p == 0) begin
            held = lane_ids_o;
            @(negedge clk_i);
            // R8: no accept, no advance
            chk(phase_o == 1'b0 && lane_ids_o == held && warp_valid_o, "R8",
                "hold without accept", int'(phase_o), 0);
          end
          accept_i = 1'b1;
          @(negedge clk_i);
          accept_i = 1'b0;
        end
        // R8: valid drops after last phase
        chk(warp_valid_o == 1'b0, "R8", "valid after last phase", int'(warp_valid_o), 0);
        nw++;
        if (nw > 16) break;
      end
      // R7 and per-vector warp count
      chk(nw == NWARPS[v], tag_of(v), "warp count", nw, NWARPS[v]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule